// File: doc/BRIEF.md
# Four-Source Prioritized Interrupt Controller

This block gathers interrupt requests from four on-chip and off-chip sources and hands the CPU core one request at a time, together with the address of its service routine. The sources are a second timer, a vertical-sync pin, a first timer and a power-input pin. The two timer sources are level requests, formed from each timer's request flag and its mask. The sync pin feeds an edge flag. The power pin feeds a latch that software can clear.

One option byte controls the block. It holds the global enable, the per-source enables and the edge polarity for each pin. Edge events are recorded even while the global enable is off. They come back as pending requests once the global enable is set again. The core reads `vec_o` while `irq_o` is high. It then pulses `ack_i`, which retires the sync edge flag if that flag was the source being granted.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `vec_o` is 0 and the option byte read on `opt_o` is 0x00.
- R2: The option byte is written only when `opt_we_i` is high and `opt_addr_i` equals 0xC8; writes to any other address leave `opt_o` unchanged. Bit map: bit0 global enable, bit1 sync enable, bit2 power enable, bit3 power edge (1 rising, 0 falling), bit5 sync edge (1 rising, 0 falling), bit6 timer-2 enable; bits 4 and 7 are stored only.
- R3: Source 1 (timer 2) requests while `tmr2_flag_i`, `tmr2_mask_i` and option bit6 are all 1, and its vector is 0x0FF6.
- R4: Source 3 (timer 1) requests while `tmr1_flag_i` and `tmr1_mask_i` are both 1, and its vector is 0x0FF2.
- R5: Source 2 (sync pin) records an edge of the polarity chosen by option bit5, but only if option bit1 is 1 when the edge arrives. A pin change made just after a falling clock edge first shows on `irq_o` after the third rising clock edge. The vector is 0x0FF4.
- R6: A recorded sync flag stays set until an `ack_i` pulse arrives while source 2 is the granted request. Each pin edge gives exactly one event, and acknowledging another source leaves the flag set.
- R7: The power latch sets on the edge selected by option bit3, but only while option bit2 is 1. It requests while it is set and bit2 is 1, and its vector is 0x0FF0. Only `pwr_clr_i` clears it, and `ack_i` does not.
- R8: `irq_o` is 0 whenever the global enable is 0. Edges that arrive during that time are still recorded, and they drive `irq_o` once the global enable returns.
- R9: When several sources request together, `vec_o` shows the vector of the lowest-numbered one, in the order timer 2, sync, timer 1, power. `vec_o` is 0 when `irq_o` is 0.
- R10: An acknowledge of a level source (timer 1, timer 2 or power) leaves that request in place, and an `ack_i` pulse while `irq_o` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opt_we_i | input | 1 | Option byte write strobe |
| opt_addr_i | input | 8 | Register address for the write |
| opt_wdata_i | input | 8 | Option byte write data |
| opt_o | output | 8 | Option byte readback |
| pwr_clr_i | input | 1 | Software clear of the power latch |
| tmr2_flag_i | input | 1 | Timer 2 request flag |
| tmr2_mask_i | input | 1 | Timer 2 request mask |
| tmr1_flag_i | input | 1 | Timer 1 request flag |
| tmr1_mask_i | input | 1 | Timer 1 request mask |
| vsync_i | input | 1 | Vertical-sync pin, asynchronous |
| pwr_pin_i | input | 1 | Power-input pin, asynchronous |
| ack_i | input | 1 | Acknowledge pulse from the core |
| irq_o | output | 1 | Request to the core |
| vec_o | output | 12 | Vector address of the granted source |

## Verification
Directed sequences drive each pin edge in both the selected and the opposite polarity. This separates polarity selection from plain edge detection, and it confirms the three-edge latency and that a held pin gives only one event. Edges made while the individual enable is off are kept apart from edges made while only the global enable is off. This shows the difference between an event that is dropped and one that is held back. Overlapping requests, with acknowledges aimed at each of them, show whether the fixed order and the single-source clear are correct. A seeded random phase then mixes timer levels, acknowledges, latch clears and option writes, both at the option address and at stray addresses, and compares the result with a bench model on every cycle.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned VEC_W   = 12;
  localparam int unsigned OPT_W   = 8;

  // option byte fields
  localparam int unsigned OPT_GLB_EN   = 0;
  localparam int unsigned OPT_SYNC_EN  = 1;
  localparam int unsigned OPT_PWR_EN   = 2;
  localparam int unsigned OPT_PWR_RISE = 3;
  localparam int unsigned OPT_SYNC_RISE = 5;
  localparam int unsigned OPT_T2_EN    = 6;

  // source slots, index = priority (0 highest)
  localparam int unsigned SRC_T2   = 0;
  localparam int unsigned SRC_SYNC = 1;
  localparam int unsigned SRC_T1   = 2;
  localparam int unsigned SRC_PWR  = 3;

  localparam logic [VEC_W-1:0] VEC_T2   = 12'hFF6;
  localparam logic [VEC_W-1:0] VEC_SYNC = 12'hFF4;
  localparam logic [VEC_W-1:0] VEC_T1   = 12'hFF2;
  localparam logic [VEC_W-1:0] VEC_PWR  = 12'hFF0;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= lvl;
    end
  end

  assign edge_o = rise_sel_i ? (lvl & ~prev_q) : (~lvl & prev_q);

  // one pin transition yields a single-cycle event
  p_edge_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o && $stable(rise_sel_i) |=> !edge_o || !$stable(rise_sel_i));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N  = 4,
  parameter int unsigned VW = 12
) (
  input  logic [N-1:0]         req_i,
  input  logic [N-1:0][VW-1:0] vec_tab_i,
  output logic [N-1:0]         grant_o,
  output logic                 any_o,
  output logic [VW-1:0]        vec_o
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    localparam logic [N-1:0] LO_MASK = N'((1 << g) - 1);
    assign grant_o[g] = req_i[g] && ((req_i & LO_MASK) == '0);
  end

  assign any_o = |req_i;

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) vec_o = vec_o | vec_tab_i[i];
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] OPT_ADDR = 8'hC8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              opt_we_i,
  input  logic [ADDR_W-1:0] opt_addr_i,
  input  logic [OPT_W-1:0]  opt_wdata_i,
  output logic [OPT_W-1:0]  opt_o,
  input  logic              pwr_clr_i,
  input  logic              tmr2_flag_i,
  input  logic              tmr2_mask_i,
  input  logic              tmr1_flag_i,
  input  logic              tmr1_mask_i,
  input  logic              vsync_i,
  input  logic              pwr_pin_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [OPT_W-1:0]              opt_q;
  logic                          opt_hit;
  logic                          sync_edge, pwr_edge;
  logic                          sync_flag_q, pwr_lat_q;
  logic [NUM_SRC-1:0]            req, grant;
  logic [NUM_SRC-1:0][VEC_W-1:0] vec_tab;
  logic                          any_req;
  logic [VEC_W-1:0]              vec_sel;
  logic                          sync_retire;

  assign opt_hit = opt_we_i && (opt_addr_i == OPT_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) opt_q <= '0;
    else if (opt_hit) opt_q <= opt_wdata_i;
  end
  assign opt_o = opt_q;

  irq_pin_edge #(.STAGES(SYNC_STAGES)) u_sync_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (vsync_i),
    .rise_sel_i (opt_q[OPT_SYNC_RISE]),
    .edge_o     (sync_edge)
  );

  irq_pin_edge #(.STAGES(SYNC_STAGES)) u_pwr_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pwr_pin_i),
    .rise_sel_i (opt_q[OPT_PWR_RISE]),
    .edge_o     (pwr_edge)
  );

  // edge flag: set beats retire so a coincident event is not lost
  assign sync_retire = ack_i && irq_o && grant[SRC_SYNC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_flag_q <= 1'b0;
    else if (sync_edge && opt_q[OPT_SYNC_EN]) sync_flag_q <= 1'b1;
    else if (sync_retire) sync_flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwr_lat_q <= 1'b0;
    else if (pwr_edge && opt_q[OPT_PWR_EN]) pwr_lat_q <= 1'b1;
    else if (pwr_clr_i) pwr_lat_q <= 1'b0;
  end

  assign req[SRC_T2]   = tmr2_flag_i && tmr2_mask_i && opt_q[OPT_T2_EN];
  assign req[SRC_SYNC] = sync_flag_q && opt_q[OPT_SYNC_EN];
  assign req[SRC_T1]   = tmr1_flag_i && tmr1_mask_i;
  assign req[SRC_PWR]  = pwr_lat_q && opt_q[OPT_PWR_EN];

  assign vec_tab = {VEC_PWR, VEC_T1, VEC_SYNC, VEC_T2};

  irq_prio_enc #(.N(NUM_SRC), .VW(VEC_W)) u_prio (
    .req_i     (req),
    .vec_tab_i (vec_tab),
    .grant_o   (grant),
    .any_o     (any_req),
    .vec_o     (vec_sel)
  );

  assign irq_o = opt_q[OPT_GLB_EN] && any_req;
  assign vec_o = irq_o ? vec_sel : '0;

  p_opt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !opt_hit |=> $stable(opt_o));

  p_t2_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && tmr2_flag_i && tmr2_mask_i && opt_o[OPT_T2_EN] |-> vec_o == VEC_T2);

  p_sync_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_flag_q && !(ack_i && irq_o && vec_o == VEC_SYNC) |=> sync_flag_q);

  p_pwr_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_lat_q && !pwr_clr_i |=> pwr_lat_q);

  p_gen_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !opt_o[OPT_GLB_EN] |-> !irq_o && vec_o == '0);
endmodule

// File: tb/irq_vec_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opt_we = 1'b0;
  logic [7:0]  opt_addr = '0;
  logic [7:0]  opt_wdata = '0;
  logic [7:0]  opt_rd;
  logic        pwr_clr = 1'b0;
  logic        t2f = 1'b0, t2m = 1'b0, t1f = 1'b0, t1m = 1'b0;
  logic        vsync = 1'b0, pwr_pin = 1'b0;
  logic        ack = 1'b0;
  logic        irq;
  logic [11:0] vec;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_vec_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .opt_we_i(opt_we), .opt_addr_i(opt_addr), .opt_wdata_i(opt_wdata), .opt_o(opt_rd),
    .pwr_clr_i(pwr_clr),
    .tmr2_flag_i(t2f), .tmr2_mask_i(t2m), .tmr1_flag_i(t1f), .tmr1_mask_i(t1m),
    .vsync_i(vsync), .pwr_pin_i(pwr_pin), .ack_i(ack),
    .irq_o(irq), .vec_o(vec)
  );

  // bench model: pending bits {pwr, t1, sync, t2}
  function automatic logic [11:0] f_vec(logic [3:0] p);
    if (p[0]) return 12'hFF6;
    if (p[1]) return 12'hFF4;
    if (p[2]) return 12'hFF2;
    if (p[3]) return 12'hFF0;
    return 12'h000;
  endfunction

  function automatic logic [3:0] f_pend(logic [7:0] o, logic s, logic w,
                                        logic a2, logic b2, logic a1, logic b1);
    return {w & o[2], a1 & b1, s & o[1], a2 & b2 & o[6]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_opt(logic [7:0] a, logic [7:0] d);
    opt_we = 1'b1; opt_addr = a; opt_wdata = d;
    step(1);
    opt_we = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  task automatic pulse_clr();
    pwr_clr = 1'b1; step(1); pwr_clr = 1'b0;
  endtask

  task automatic chk_out(string req, logic i, logic [11:0] v);
    #1;
    chk(req, {31'd0, irq}, {31'd0, i});
    chk(req, {20'd0, vec}, {20'd0, v});
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] m_opt;
    logic       m_sync, m_pwr;
    void'($urandom(32'h5eed_1234));
    step(3);
    // R1 reset state
    chk_out("R1", 1'b0, 12'h000);
    chk("R1", {24'd0, opt_rd}, 32'h00);
    rst_n = 1'b1;
    step(2);

    // R2 address decode
    wr_opt(8'h55, 8'hFF);
    #1 chk("R2", {24'd0, opt_rd}, 32'h00);
    step(1);
    wr_opt(8'hC8, 8'h41);
    #1 chk("R2", {24'd0, opt_rd}, 32'h41);

    // R3 timer 2 level
    t2f = 1'b1; t2m = 1'b0;
    chk_out("R3", 1'b0, 12'h000);
    t2m = 1'b1;
    chk_out("R3", 1'b1, 12'hFF6);
    step(1);
    wr_opt(8'hC8, 8'h01);
    chk_out("R3", 1'b0, 12'h000);
    t2f = 1'b0; t2m = 1'b0;

    // R4 / R10 timer 1 level, ack leaves it
    t1f = 1'b1; t1m = 1'b1;
    chk_out("R4", 1'b1, 12'hFF2);
    step(1);
    pulse_ack();
    chk_out("R10", 1'b1, 12'hFF2);
    t1f = 1'b0;
    chk_out("R4", 1'b0, 12'h000);
    t1m = 1'b0;
    step(1);

    // R5 falling select, latency
    wr_opt(8'hC8, 8'h03);
    vsync = 1'b1; step(4);
    chk_out("R5", 1'b0, 12'h000);
    step(1);
    vsync = 1'b0; step(2);
    chk_out("R5", 1'b0, 12'h000);
    step(1);
    chk_out("R5", 1'b1, 12'hFF4);
    step(6);
    chk_out("R6", 1'b1, 12'hFF4);
    step(1);
    pulse_ack();
    chk_out("R6", 1'b0, 12'h000);
    step(5);
    chk_out("R6", 1'b0, 12'h000);

    // R10 ack while idle
    step(1);
    pulse_ack();
    chk_out("R10", 1'b0, 12'h000);
    step(1);

    // R5 rising select
    wr_opt(8'hC8, 8'h23);
    vsync = 1'b1; step(3);
    chk_out("R5", 1'b1, 12'hFF4);
    step(1);
    pulse_ack();
    chk_out("R6", 1'b0, 12'h000);
    step(1);

    // R5 individual disable drops the event
    wr_opt(8'hC8, 8'h21);
    vsync = 1'b0; step(4);
    vsync = 1'b1; step(4);
    wr_opt(8'hC8, 8'h23);
    chk_out("R5", 1'b0, 12'h000);
    step(1);

    // R8 global disable keeps capturing
    wr_opt(8'hC8, 8'h22);
    vsync = 1'b0; step(4);
    vsync = 1'b1; step(4);
    chk_out("R8", 1'b0, 12'h000);
    step(1);
    wr_opt(8'hC8, 8'h23);
    chk_out("R8", 1'b1, 12'hFF4);

    // R9 priority, R6 ack of other source keeps flag
    t1f = 1'b1; t1m = 1'b1;
    chk_out("R9", 1'b1, 12'hFF4);
    step(1);
    wr_opt(8'hC8, 8'h63);
    t2f = 1'b1; t2m = 1'b1;
    chk_out("R9", 1'b1, 12'hFF6);
    step(1);
    pulse_ack();
    t2f = 1'b0;
    chk_out("R6", 1'b1, 12'hFF4);
    step(1);
    pulse_ack();
    chk_out("R9", 1'b1, 12'hFF2);
    t1f = 1'b0; t1m = 1'b0; t2m = 1'b0;
    chk_out("R9", 1'b0, 12'h000);
    step(1);

    // R7 power latch
    wr_opt(8'hC8, 8'h0D);
    pwr_pin = 1'b1; step(3);
    chk_out("R7", 1'b1, 12'hFF0);
    step(1);
    pulse_ack();
    step(2);
    chk_out("R10", 1'b1, 12'hFF0);
    step(1);
    pulse_clr();
    chk_out("R7", 1'b0, 12'h000);
    step(1);
    wr_opt(8'hC8, 8'h05);
    pwr_pin = 1'b0; step(3);
    chk_out("R7", 1'b1, 12'hFF0);
    step(1);
    pulse_clr();
    chk_out("R7", 1'b0, 12'h000);
    step(1);
    wr_opt(8'hC8, 8'h09);
    pwr_pin = 1'b1; step(4);
    wr_opt(8'hC8, 8'h0D);
    chk_out("R7", 1'b0, 12'h000);
    step(1);

    // prepare random phase with both event sources recorded
    wr_opt(8'hC8, 8'h2F);
    vsync = 1'b0; pwr_pin = 1'b0; step(4);
    vsync = 1'b1; pwr_pin = 1'b1; step(4);
    chk_out("R9", 1'b1, 12'hFF4);
    vsync = 1'b0; pwr_pin = 1'b0;
    step(4);
    m_opt = 8'h2F; m_sync = 1'b1; m_pwr = 1'b1;

    // random phase
    for (int it = 0; it < 600; it++) begin
      logic [3:0]  p;
      logic        e_irq;
      logic [11:0] e_vec;
      logic [31:0] r;
      step(1);
      r = $urandom;
      t2f = r[0]; t2m = r[1]; t1f = r[2]; t1m = r[3];
      ack = (r[5:4] == 2'b00);
      pwr_clr = (r[9:6] == 4'h0);
      opt_we = (r[12:10] == 3'b000);
      opt_addr = r[13] ? 8'hC8 : r[21:14];
      opt_wdata = r[29:22];
      #1;
      p = f_pend(m_opt, m_sync, m_pwr, t2f, t2m, t1f, t1m);
      e_irq = m_opt[0] && (p != 4'd0);
      e_vec = e_irq ? f_vec(p) : 12'h000;
      chk("R9", {31'd0, irq}, {31'd0, e_irq});
      chk("R9", {20'd0, vec}, {20'd0, e_vec});
      chk("R2", {24'd0, opt_rd}, {24'd0, m_opt});
      if (ack && e_irq && p[1] && !p[0]) m_sync = 1'b0;
      if (pwr_clr) m_pwr = 1'b0;
      if (opt_we && opt_addr == 8'hC8) m_opt = opt_wdata;
    end
    step(1);
    ack = 1'b0; pwr_clr = 1'b0; opt_we = 1'b0;
    step(1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule